// File: doc/BRIEF.md
# Dual-Clock Word FIFO Synchronizer

This block carries complete data words from one clock domain into a second, unrelated clock domain without tearing a word. The producer side runs on its own clock and synchronous reset. It presents a word together with a valid qualifier and watches a full flag. The consumer side runs on a separate clock and synchronous reset. It sees the oldest stored word on its data output at all times, watches an empty flag, and raises a read request to step past that word.

Words are held in a register array with a combinational read port. Its capacity is a power of two, set by an address-width parameter that must be at least 2. Each side keeps a binary pointer one bit wider than the address, plus a Gray-coded copy of it. Each Gray pointer crosses into the opposite domain through a two-flop synchronizer. Because only one bit of a Gray pointer changes per step, a pointer sampled mid-transition resolves to either its old or its new value. The flags are therefore conservative: empty can linger and full can linger, but neither is ever released early.

The read port is show-ahead. A read request does not fetch data. It only moves the read pointer, and the next word appears on the output through the combinational read path. The output word has no defined value while empty is high.

Top module: `asyncFifoSync`

## Requirements
- R1: After both resets have been applied, rdEmpty is 1 and wrFull is 0.
- R2: Whenever rdEmpty is 0, rdData equals the oldest word accepted and not yet read. Words leave in the order they were accepted.
- R3: A word is accepted on a rising wrClk edge only when wrValid is 1 and wrFull is 0. Words presented with wrValid at 0 never appear at rdData.
- R4: Capacity is exactly 2^ADDR_W words. With no reads, wrFull rises after exactly 2^ADDR_W accepted writes. Once both sides are idle and the flags have settled, rdEmpty equals (stored count == 0) and wrFull equals (stored count == 2^ADDR_W).
- R5: A write presented while wrFull is 1 is ignored. The stored words and their order are unchanged, and no extra word appears at the output.
- R6: A read request while rdEmpty is 1 is ignored. A word written later is still delivered, and it is delivered exactly once.
- R7: rdEmpty is 1 in every read cycle in which no unread word exists, including the cycle straight after the read that takes the last word.
- R8: wrFull is 1 in every write cycle in which 2^ADDR_W unread words are held, including the cycle straight after the write that fills the last slot.
- R9: Each Gray-coded pointer sent across domains changes in at most one bit per cycle of its source clock. A read request with rdEmpty at 0, or a write with wrValid 1 and wrFull 0, advances the pointer of that side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-domain clock |
| wrRst | input | 1 | Write-domain synchronous reset, active high |
| wrValid | input | 1 | Qualifies wrData as a word to store |
| wrData | input | DATA_W | Word to store |
| wrFull | output | 1 | No free slot, as seen from the write domain |
| rdClk | input | 1 | Read-domain clock |
| rdRst | input | 1 | Read-domain synchronous reset, active high |
| rdReq | input | 1 | Step past the word shown on rdData |
| rdData | output | DATA_W | Oldest unread word (show-ahead) |
| rdEmpty | output | 1 | No unread word, as seen from the read domain |

## Verification
The pointer properties assume each reset is held for at least the synchronizer depth in its own clock domain. They also assume wrValid, wrData and rdReq only change away from the rising edge of their own clock. The stimulus holds both resets together for many cycles of both clocks. It changes producer inputs only on falling wrClk edges and consumer inputs only on falling rdClk edges. The two clock periods, 4 ns and 7 ns, are chosen so that their edges drift against each other. The bench deliberately drives writes into a full FIFO and reads from an empty one, so the properties that keep the pointers still in those cases are exercised and not only assumed.

// File: rtl/afifoPkg.sv
`timescale 1ns/1ps
package afifoPkg;

  // Per-cycle strobes from the pointer control to the storage datapath.
  typedef struct packed {
    logic wrEn;   // store wrData into the slot at the write address
    logic rdAdv;  // consumer steps past the oldest word
  } fifoStrobe_t;

endpackage

// File: rtl/afifoSync2.sv
`timescale 1ns/1ps
// Multi-flop level synchronizer for a Gray-coded pointer.
module afifoSync2 #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stage [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= '0;
          else     stage[0] <= dIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= '0;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign dOut = stage[STAGES-1];

endmodule

// File: rtl/afifoCtrl.sv
`timescale 1ns/1ps
// Pointer control for both domains: binary and Gray pointers, flags, strobes.
module afifoCtrl
  import afifoPkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int PTR_W = ADDR_W + 1
) (
  // write domain
  input  logic              wrClk,
  input  logic              wrRst,
  input  logic              wrValid,
  input  logic [PTR_W-1:0]  rdGraySync,
  output logic              wrFull,
  output logic [PTR_W-1:0]  wrGray,
  output logic [ADDR_W-1:0] wrAddr,
  // read domain
  input  logic              rdClk,
  input  logic              rdRst,
  input  logic              rdReq,
  input  logic [PTR_W-1:0]  wrGraySync,
  output logic              rdEmpty,
  output logic [PTR_W-1:0]  rdGray,
  output logic [ADDR_W-1:0] rdAddr,
  // strobes to the datapath
  output fifoStrobe_t       strobe
);

  logic [PTR_W-1:0] wrBin, wrBinNext, wrGrayNext;
  logic [PTR_W-1:0] rdBin, rdBinNext, rdGrayNext;
  logic [PTR_W-1:0] fullPattern;

  // ---------------- write domain ----------------
  // Full: the write pointer has lapped the read pointer by one whole capacity.
  // In Gray form, this means the top two bits differ and all other bits match.
  assign fullPattern = {~rdGraySync[PTR_W-1:PTR_W-2], rdGraySync[PTR_W-3:0]};
  assign wrFull      = (wrGray == fullPattern);
  assign strobe.wrEn = wrValid & ~wrFull;

  assign wrBinNext  = wrBin + PTR_W'(strobe.wrEn);
  assign wrGrayNext = wrBinNext ^ (wrBinNext >> 1);

  always_ff @(posedge wrClk) begin
    if (wrRst) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else begin
      wrBin  <= wrBinNext;
      wrGray <= wrGrayNext;
    end
  end

  assign wrAddr = wrBin[ADDR_W-1:0];

  // ---------------- read domain ----------------
  assign rdEmpty      = (rdGray == wrGraySync);
  assign strobe.rdAdv = rdReq & ~rdEmpty;

  assign rdBinNext  = rdBin + PTR_W'(strobe.rdAdv);
  assign rdGrayNext = rdBinNext ^ (rdBinNext >> 1);

  always_ff @(posedge rdClk) begin
    if (rdRst) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= rdGrayNext;
    end
  end

  assign rdAddr = rdBin[ADDR_W-1:0];

endmodule

// File: rtl/afifoMem.sv
`timescale 1ns/1ps
// Storage datapath: register array, write port on wrClk, combinational read port.
module afifoMem
  import afifoPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wrClk,
  input  fifoStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] slot [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.wrEn) slot[wrAddr] <= wrData;
  end

  assign rdData = slot[rdAddr];

endmodule

// File: rtl/asyncFifoSync.sv
`timescale 1ns/1ps
// Dual-clock FIFO for moving whole words between unrelated clock domains.
module asyncFifoSync
  import afifoPkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              wrClk,
  input  logic              wrRst,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFull,
  input  logic              rdClk,
  input  logic              rdRst,
  input  logic              rdReq,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEmpty
);

  localparam int PTR_W = ADDR_W + 1;

  fifoStrobe_t       strobe;
  logic [PTR_W-1:0]  wrGray, rdGray, wrGraySync, rdGraySync;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  afifoCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrClk(wrClk), .wrRst(wrRst), .wrValid(wrValid), .rdGraySync(rdGraySync),
    .wrFull(wrFull), .wrGray(wrGray), .wrAddr(wrAddr),
    .rdClk(rdClk), .rdRst(rdRst), .rdReq(rdReq), .wrGraySync(wrGraySync),
    .rdEmpty(rdEmpty), .rdGray(rdGray), .rdAddr(rdAddr),
    .strobe(strobe)
  );

  afifoMem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .wrClk(wrClk), .strobe(strobe), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  // write pointer into the read domain
  afifoSync2 #(.WIDTH(PTR_W), .STAGES(SYNC_DEPTH)) u_syncWr (
    .clk(rdClk), .rst(rdRst), .dIn(wrGray), .dOut(wrGraySync)
  );

  // read pointer into the write domain
  afifoSync2 #(.WIDTH(PTR_W), .STAGES(SYNC_DEPTH)) u_syncRd (
    .clk(wrClk), .rst(wrRst), .dIn(rdGray), .dOut(rdGraySync)
  );

endmodule

// File: rtl/afifoChecker.sv
`timescale 1ns/1ps
module afifoChecker #(
  parameter int ADDR_W = 3,
  localparam int PTR_W = ADDR_W + 1
) (
  input logic             wrClk,
  input logic             wrRst,
  input logic             wrValid,
  input logic             wrFull,
  input logic [PTR_W-1:0] wrGray,
  input logic             rdClk,
  input logic             rdRst,
  input logic             rdReq,
  input logic             rdEmpty,
  input logic [PTR_W-1:0] rdGray
);

  assert_wr_gray_step_R9: assert property (@(posedge wrClk) disable iff (wrRst)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  assert_rd_gray_step_R9: assert property (@(posedge rdClk) disable iff (rdRst)
    $countones(rdGray ^ $past(rdGray)) <= 1);

  assert_no_overflow_R5: assert property (@(posedge wrClk) disable iff (wrRst)
    (wrValid && wrFull) |=> $stable(wrGray));

  assert_no_underflow_R6: assert property (@(posedge rdClk) disable iff (rdRst)
    (rdEmpty && !$past(rdRst)) |=> $stable(rdGray));

  assert_write_advances_R3: assert property (@(posedge wrClk) disable iff (wrRst)
    (wrValid && !wrFull) |=> (wrGray != $past(wrGray)));

  assert_read_advances_R2: assert property (@(posedge rdClk) disable iff (rdRst)
    (rdReq && !rdEmpty) |=> (rdGray != $past(rdGray)));

endmodule

bind asyncFifoSync afifoChecker #(.ADDR_W(ADDR_W)) u_chk (
  .wrClk(wrClk), .wrRst(wrRst), .wrValid(wrValid), .wrFull(wrFull), .wrGray(wrGray),
  .rdClk(rdClk), .rdRst(rdRst), .rdReq(rdReq), .rdEmpty(rdEmpty), .rdGray(rdGray)
);

// File: tb/asyncFifoSync_tb.sv
`timescale 1ns/1ps
module asyncFifoSync_tb;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic wrClk = 1'b0, rdClk = 1'b0;
  logic wrRst = 1'b1, rdRst = 1'b1;
  logic wrValid = 1'b0, rdReq = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic wrFull, rdEmpty;

  int vectors = 0;
  int miscompares = 0;
  bit checking = 1'b0;
  bit finished = 1'b0;
  string dataReq = "R2";
  int model[$];

  always #2   wrClk = ~wrClk;   // 250 MHz
  always #3.5 rdClk = ~rdClk;   // unrelated slower clock

  asyncFifoSync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .wrClk(wrClk), .wrRst(wrRst), .wrValid(wrValid), .wrData(wrData), .wrFull(wrFull),
    .rdClk(rdClk), .rdRst(rdRst), .rdReq(rdReq), .rdData(rdData), .rdEmpty(rdEmpty)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model: push/pop on the edges using values seen before the edge
  always @(posedge wrClk)
    if (!wrRst && wrValid && !wrFull) model.push_back(int'(wrData));

  always @(posedge rdClk)
    if (!rdRst && rdReq && !rdEmpty && model.size() > 0) void'(model.pop_front());

  // per-clock comparisons, away from the active edges
  always @(negedge rdClk) if (checking) begin
    if (!rdEmpty) begin
      if (model.size() == 0)
        check(1'b0, "R7", "rdEmpty low with no unread word", 0, 1);
      else
        check(int'(rdData) == model[0], dataReq, "rdData oldest word", int'(rdData), model[0]);
    end else begin
      check(1'b1, "R7", "rdEmpty", 1, 1);
    end
  end

  always @(negedge wrClk) if (checking) begin
    if (model.size() >= DEPTH)
      check(wrFull == 1'b1, "R8", "wrFull with capacity held", int'(wrFull), 1);
  end

  task automatic settle();
    repeat (12) @(negedge rdClk);
    repeat (12) @(negedge wrClk);
  endtask

  task automatic checkSettled(input string req);
    check(rdEmpty == (model.size() == 0), req, "settled rdEmpty", int'(rdEmpty),
          int'(model.size() == 0));
    check(wrFull == (model.size() == DEPTH), req, "settled wrFull", int'(wrFull),
          int'(model.size() == DEPTH));
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int accepted;
    repeat (10) @(negedge rdClk);
    @(negedge wrClk); wrRst = 1'b0;
    @(negedge rdClk); rdRst = 1'b0;
    @(negedge wrClk);
    // R1: reset state
    check(rdEmpty == 1'b1, "R1", "rdEmpty after reset", int'(rdEmpty), 1);
    check(wrFull == 1'b0, "R1", "wrFull after reset", int'(wrFull), 0);
    checking = 1'b1;

    // R4: fill with no reads, count accepted words until full
    accepted = 0;
    while (!wrFull && accepted < 4 * DEPTH) begin
      wrValid = 1'b1; wrData = DATA_W'(8'h10 + accepted);
      @(negedge wrClk);
      accepted++;
    end
    wrValid = 1'b0;
    check(accepted == DEPTH, "R4", "writes accepted before full", accepted, DEPTH);
    check(model.size() == DEPTH, "R4", "model count at full", model.size(), DEPTH);

    // R5: hammer writes while full
    dataReq = "R5";
    repeat (6) begin
      wrValid = 1'b1; wrData = 8'hEE;
      @(negedge wrClk);
    end
    wrValid = 1'b0;
    check(model.size() == DEPTH, "R5", "count after writes while full", model.size(), DEPTH);
    settle();
    checkSettled("R4");
    check(int'(rdData) == 8'h10, "R5", "head word unchanged", int'(rdData), 8'h10);

    // drain everything, then R6: read requests while empty
    @(negedge rdClk); rdReq = 1'b1;
    while (!rdEmpty) @(negedge rdClk);
    dataReq = "R6";
    repeat (15) @(negedge rdClk);
    rdReq = 1'b0;
    settle();
    checkSettled("R6");
    @(negedge wrClk); wrValid = 1'b1; wrData = 8'hA5;
    @(negedge wrClk); wrValid = 1'b0;
    settle();
    check(rdEmpty == 1'b0, "R6", "rdEmpty after write following underflow", int'(rdEmpty), 0);
    check(int'(rdData) == 8'hA5, "R6", "word after underflow", int'(rdData), 8'hA5);
    @(negedge rdClk); rdReq = 1'b1;
    @(negedge rdClk); rdReq = 1'b0;
    check(rdEmpty == 1'b1, "R7", "empty right after last read", int'(rdEmpty), 1);
    settle();
    checkSettled("R6");

    // R3 and R2: mixed traffic with gaps in wrValid, two rate mixes
    dataReq = "R3";
    for (int mix = 0; mix < 2; mix++) begin
      fork
        begin
          for (int n = 0; n < 3000; n++) begin
            @(negedge wrClk);
            wrValid = (mix == 0) ? ($urandom % 3 != 0) : ($urandom % 4 == 0);
            wrData = DATA_W'($urandom);
          end
          @(negedge wrClk); wrValid = 1'b0;
        end
        begin
          for (int n = 0; n < 1700; n++) begin
            @(negedge rdClk);
            rdReq = (mix == 0) ? ($urandom % 2 == 0) : ($urandom % 5 != 0);
          end
          @(negedge rdClk); rdReq = 1'b0;
        end
      join
      settle();
      checkSettled("R4");
      dataReq = "R2";
    end

    // final drain
    @(negedge rdClk); rdReq = 1'b1;
    repeat (4 * DEPTH) @(negedge rdClk);
    rdReq = 1'b0;
    settle();
    checkSettled("R7");
    check(model.size() == 0, "R2", "all words delivered", model.size(), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule